// File: doc/BRIEF.md
# Receive Descriptor Ring Accounting

This block keeps the books for a circular ring of receive descriptors. It holds the head index, which the block advances as it consumes descriptors, and the tail index, which software writes to hand descriptors back. For each incoming frame it receives the frame length, the ethertype field found at byte offset 12 and the 12-bit tag that follows it. It then decides whether the frame is taken or dropped, and for a taken frame it issues one descriptor update record per cycle, each with a ring index, a length and a status byte.

The buffer size behind every descriptor comes from a compact receive control word. Before a frame is taken, the block reserves enough descriptors for a frame of the largest allowed size. It also applies a 4096-bit tag filter table. When a frame completes, it raises interrupt cause bits: frame received, small frame, and ring running low. Moving the frame data itself is left to the surrounding logic. Frame lengths presented to the block do not exceed the largest allowed frame size less the 4 bytes added for the checksum trailer.

Control word layout (11 bits): bit 0 receive enable; bits 2:1 loopback mode (any nonzero value means loopback); bit 3 long-frame enable; bits 5:4 buffer size code; bit 6 size extension; bit 7 tag filter enable; bits 9:8 low-threshold fraction; bit 10 strip checksum trailer.

Top module: `rxr_ring_acct`

## Requirements
- R1: The buffer size is decoded from the size code and the extension bit. With extension 0, codes 0, 1, 2 and 3 give 2048, 1024, 512 and 256 bytes. With extension 1, codes 1, 2 and 3 give 16384, 8192 and 4096 bytes, and code 0 falls back to 256 bytes. The ring size in descriptors is the ring byte length divided by 16.
- R2: Free descriptors are (size + tail - head) mod size, and 0 when size is 0. The reserved count is the ceiling of the largest frame size over the buffer size, where the largest frame size is 16384 with long frames enabled and 1522 otherwise. When free < reserved, the frame is dropped, drop_o pulses for one cycle, miss_cnt_o increments by one and no descriptor is written.
- R3: The adjusted length is the frame length raised to at least 60. Then 4 is added unless the strip bit is set.
- R4: A taken frame uses ceiling(adjusted length / buffer size) descriptors, emitted one per cycle at indices head, head+1 and so on, starting the cycle after acceptance. Every descriptor except the last reports the buffer size with status 0x01 (done). The last reports the adjusted length mod the buffer size with status 0x07 (done bit 0, end-of-frame bit 1, checksum-ignore bit 2).
- R5: The head index advances by one per emitted descriptor and wraps to 0 when it reaches the ring size.
- R6: When the tag filter is enabled and the frame's ethertype equals cfg_vlan_type, table bit (word tag[11:5], bit tag[4:0]) is looked up. If that bit is 0, the frame is dropped with a drop_o pulse, no descriptors and no change to miss_cnt_o. The ring-space check of R2 is made before the tag check.
- R7: In the cycle after a taken frame's last descriptor, cause_o bit 0 (received) pulses. Bit 1 (small frame) pulses with it when the adjusted length is at most cfg_small_thr.
- R8: In that same cycle, cause_o bit 2 (ring low) pulses when the free count after the head update is below size >> (fraction + 1).
- R9: A frame presented while receive is disabled or loopback is nonzero is dropped with a drop_o pulse. Head, miss_cnt_o and cause_o are left unchanged.
- R10: frm_ready_o is low while descriptors are being emitted, and frm_valid_i is ignored in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctrl_i | input | 11 | Receive control word |
| cfg_ring_bytes_i | input | IDX_W+4 | Ring length in bytes (multiple of 16) |
| cfg_vlan_type_i | input | 16 | Ethertype that marks a tagged frame |
| cfg_small_thr_i | input | THR_W | Small-frame threshold in bytes |
| tail_we_i | input | 1 | Tail index write strobe |
| tail_wdata_i | input | IDX_W | New tail index |
| vt_we_i | input | 1 | Tag filter table word write strobe |
| vt_addr_i | input | VID_W-5 | Tag filter table word address |
| vt_wdata_i | input | 32 | Tag filter table word data |
| frm_valid_i | input | 1 | Frame present |
| frm_ready_o | output | 1 | Block can accept a frame |
| frm_len_i | input | LEN_W | Frame length in bytes |
| frm_type_i | input | 16 | Ethertype field of the frame |
| frm_vid_i | input | VID_W | Tag identifier of the frame |
| desc_valid_o | output | 1 | Descriptor update record valid |
| desc_idx_o | output | IDX_W | Ring index of the record |
| desc_len_o | output | LEN_W+1 | Length written to the descriptor |
| desc_status_o | output | 8 | Status written to the descriptor |
| head_o | output | IDX_W | Current head index |
| tail_o | output | IDX_W | Current tail index |
| drop_o | output | 1 | Frame dropped (one-cycle pulse) |
| cause_o | output | 3 | Interrupt causes: 0 received, 1 small, 2 ring low |
| miss_cnt_o | output | MISS_W | Frames dropped for lack of ring space |

## Verification
The hardest situations to reach are a frame whose free count sits just below the worst-case reservation, and a ring-low pulse that depends on where the head lands after wrapping. Both depend on the exact spacing between head and tail at the moment a frame arrives. The bench moves the tail to chosen offsets from its own model of the head before directed frames, for example zero or five free descriptors against a reservation of six. In the random phase it rewrites the tail and the ring size between frames, so that the reservation, the wrap and the threshold boundaries are all crossed with every buffer size code.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int CTRL_W   = 11;
   localparam int C_EN     = 0;
   localparam int C_LBK_LO = 1;
   localparam int C_LONG   = 3;
   localparam int C_SZ_LO  = 4;
   localparam int C_EXT    = 6;
   localparam int C_VFE    = 7;
   localparam int C_MTS_LO = 8;
   localparam int C_STRIP  = 10;

   localparam logic [7:0] ST_MID  = 8'h01;
   localparam logic [7:0] ST_LAST = 8'h07;

   localparam int CZ_RX    = 0;
   localparam int CZ_SMALL = 1;
   localparam int CZ_LOW   = 2;

   typedef enum logic {S_IDLE, S_EMIT} rxr_state_t;
endpackage

// File: rtl/rxr_bufsz_dec.sv
module rxr_bufsz_dec (
   input  logic [1:0] sz_code_i,
   input  logic       ext_i,
   output logic [3:0] lg_o
);
   always_comb begin
      if (!ext_i) begin
         lg_o = 4'd11 - {2'b00, sz_code_i};
      end else if (sz_code_i == 2'd0) begin
         lg_o = 4'd8;
      end else begin
         lg_o = 4'd15 - {2'b00, sz_code_i};
      end
   end
endmodule

// File: rtl/rxr_ring_calc.sv
module rxr_ring_calc #(
   parameter int AW = 13
) (
   input  logic [AW-1:0] size_i,
   input  logic [AW-1:0] head_i,
   input  logic [AW-1:0] tail_i,
   output logic [AW-1:0] avail_o
);
   always_comb begin
      if (size_i == '0)           avail_o = '0;
      else if (tail_i >= head_i)  avail_o = tail_i - head_i;
      else                        avail_o = size_i - head_i + tail_i;
   end
endmodule

// File: rtl/rxr_vlan_table.sv
module rxr_vlan_table #(
   parameter int VID_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [VID_W-6:0] waddr_i,
   input  logic [31:0]      wdata_i,
   input  logic [VID_W-6:0] raddr_i,
   output logic [31:0]      rword_o
);
   localparam int WORDS = 1 << (VID_W - 5);
   logic [31:0] mem_q [WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
      end else if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   assign rword_o = mem_q[raddr_i];
endmodule

// File: rtl/rxr_ring_acct.sv
module rxr_ring_acct
   import rxr_pkg::*;
#(
   parameter int IDX_W  = 12,
   parameter int LEN_W  = 16,
   parameter int VID_W  = 12,
   parameter int THR_W  = 16,
   parameter int MISS_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CTRL_W-1:0]      cfg_ctrl_i,
   input  logic [IDX_W+3:0]       cfg_ring_bytes_i,
   input  logic [15:0]            cfg_vlan_type_i,
   input  logic [THR_W-1:0]       cfg_small_thr_i,
   input  logic                   tail_we_i,
   input  logic [IDX_W-1:0]       tail_wdata_i,
   input  logic                   vt_we_i,
   input  logic [VID_W-6:0]       vt_addr_i,
   input  logic [31:0]            vt_wdata_i,
   input  logic                   frm_valid_i,
   output logic                   frm_ready_o,
   input  logic [LEN_W-1:0]       frm_len_i,
   input  logic [15:0]            frm_type_i,
   input  logic [VID_W-1:0]       frm_vid_i,
   output logic                   desc_valid_o,
   output logic [IDX_W-1:0]       desc_idx_o,
   output logic [LEN_W:0]         desc_len_o,
   output logic [7:0]             desc_status_o,
   output logic [IDX_W-1:0]       head_o,
   output logic [IDX_W-1:0]       tail_o,
   output logic                   drop_o,
   output logic [2:0]             cause_o,
   output logic [MISS_W-1:0]      miss_cnt_o
);
   localparam int AW  = IDX_W + 1;
   localparam int LW  = LEN_W + 1;
   localparam int CW0 = (AW > LW) ? AW : LW;
   localparam int CW  = (CW0 > THR_W) ? CW0 : THR_W;

   if (IDX_W < 2 || IDX_W > 16) begin : g_bad_idx
      $error("rxr_ring_acct: IDX_W out of range");
   end
   if (LEN_W < 14) begin : g_bad_len
      $error("rxr_ring_acct: LEN_W must hold a 16384-byte frame");
   end
   if (VID_W < 6) begin : g_bad_vid
      $error("rxr_ring_acct: VID_W too small for a word-organised table");
   end

   rxr_state_t     st_q;
   logic [AW-1:0]  size_w, head_q, tail_q, head_p1, head_nx;
   logic [AW-1:0]  avail_now, avail_nx, low_lim;
   logic [3:0]     lg;
   logic [LW-1:0]  buf_w, bufm1, len_min, adj, maxfr, resv, n_w;
   logic [LW-1:0]  rem_q, buf_q, last_q;
   logic [1:0]     mts_q;
   logic           small_q, room_ok, small_w, low_w, rx_off, vlan_rej;
   logic [31:0]    vt_word;
   logic           drop_q;
   logic [2:0]     cause_q;
   logic [MISS_W-1:0] miss_q;

   assign size_w  = {1'b0, cfg_ring_bytes_i[IDX_W+3:4]};
   assign head_p1 = head_q + AW'(1);
   assign head_nx = (head_p1 >= size_w) ? '0 : head_p1;

   rxr_bufsz_dec u_dec (
      .sz_code_i (cfg_ctrl_i[C_SZ_LO +: 2]),
      .ext_i     (cfg_ctrl_i[C_EXT]),
      .lg_o      (lg)
   );

   rxr_ring_calc #(.AW(AW)) u_avail_now (
      .size_i (size_w), .head_i (head_q), .tail_i (tail_q), .avail_o (avail_now)
   );
   rxr_ring_calc #(.AW(AW)) u_avail_nx (
      .size_i (size_w), .head_i (head_nx), .tail_i (tail_q), .avail_o (avail_nx)
   );

   rxr_vlan_table #(.VID_W(VID_W)) u_vt (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (vt_we_i),
      .waddr_i (vt_addr_i),
      .wdata_i (vt_wdata_i),
      .raddr_i (frm_vid_i[VID_W-1:5]),
      .rword_o (vt_word)
   );

   assign buf_w   = LW'(1) << lg;
   assign bufm1   = buf_w - LW'(1);
   assign len_min = ({1'b0, frm_len_i} < LW'(60)) ? LW'(60) : {1'b0, frm_len_i};
   assign adj     = len_min + (cfg_ctrl_i[C_STRIP] ? LW'(0) : LW'(4));
   assign maxfr   = cfg_ctrl_i[C_LONG] ? LW'(16384) : LW'(1522);
   assign resv    = (maxfr + bufm1) >> lg;
   assign n_w     = (adj + bufm1) >> lg;
   assign room_ok = CW'(avail_now) >= CW'(resv);
   assign small_w = CW'(adj) <= CW'(cfg_small_thr_i);
   assign low_lim = size_w >> ({1'b0, mts_q} + 3'd1);
   assign low_w   = avail_nx < low_lim;
   assign rx_off  = !cfg_ctrl_i[C_EN] || (cfg_ctrl_i[C_LBK_LO +: 2] != 2'b00);
   assign vlan_rej = cfg_ctrl_i[C_VFE] && (frm_type_i == cfg_vlan_type_i) &&
                     !vt_word[frm_vid_i[4:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         head_q  <= '0;
         tail_q  <= '0;
         rem_q   <= '0;
         buf_q   <= '0;
         last_q  <= '0;
         mts_q   <= '0;
         small_q <= 1'b0;
         drop_q  <= 1'b0;
         cause_q <= '0;
         miss_q  <= '0;
      end else begin
         drop_q  <= 1'b0;
         cause_q <= '0;
         if (tail_we_i) tail_q <= {1'b0, tail_wdata_i};
         case (st_q)
            S_IDLE: begin
               if (frm_valid_i) begin
                  if (rx_off) begin
                     drop_q <= 1'b1;
                  end else if (!room_ok) begin
                     drop_q <= 1'b1;
                     miss_q <= miss_q + MISS_W'(1);
                  end else if (vlan_rej) begin
                     drop_q <= 1'b1;
                  end else begin
                     st_q    <= S_EMIT;
                     rem_q   <= n_w;
                     buf_q   <= buf_w;
                     last_q  <= adj & bufm1;
                     small_q <= small_w;
                     mts_q   <= cfg_ctrl_i[C_MTS_LO +: 2];
                  end
               end
            end
            S_EMIT: begin
               head_q <= head_nx;
               if (rem_q == LW'(1)) begin
                  st_q    <= S_IDLE;
                  cause_q <= {low_w, small_q, 1'b1};
               end else begin
                  rem_q <= rem_q - LW'(1);
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign frm_ready_o   = (st_q == S_IDLE);
   assign desc_valid_o  = (st_q == S_EMIT);
   assign desc_idx_o    = head_q[IDX_W-1:0];
   assign desc_len_o    = (rem_q == LW'(1)) ? last_q : buf_q;
   assign desc_status_o = (rem_q == LW'(1)) ? ST_LAST : ST_MID;
   assign head_o        = head_q[IDX_W-1:0];
   assign tail_o        = tail_q[IDX_W-1:0];
   assign drop_o        = drop_q;
   assign cause_o       = cause_q;
   assign miss_cnt_o    = miss_q;

   // R1: ring length is given in whole 16-byte descriptors
   assert_ring_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ring_bytes_i[3:0] == 4'd0);

   // R2: a dropped frame writes no descriptor in the same cycle
   assert_drop_no_desc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |-> !desc_valid_o);

   // R2: the missed counter moves only together with a drop pulse
   assert_miss_only_on_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_o |-> $stable(miss_cnt_o));

   // R5: the head wraps to zero after the last ring slot
   assert_head_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid_o && size_w != '0 && head_q == size_w - AW'(1)) |=> (head_q == '0));

   // R7: every completed frame pulses the received cause
   assert_rx_cause_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(desc_valid_o) |-> cause_o[CZ_RX]);

   // R7: the small-frame cause never appears without the received cause
   assert_small_needs_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cause_o[CZ_SMALL] |-> cause_o[CZ_RX]);

   // R9: the head never moves unless a descriptor is being written
   assert_head_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !desc_valid_o |=> $stable(head_q));
endmodule

// File: tb/rxr_ring_acct_tb_top.sv
module rxr_ring_acct_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] cfg_ctrl = '0;
   logic [15:0] cfg_ring_bytes = '0;
   logic [15:0] cfg_vlan_type = '0;
   logic [15:0] cfg_small_thr = '0;
   logic        tail_we = 1'b0;
   logic [11:0] tail_wdata = '0;
   logic        vt_we = 1'b0;
   logic [6:0]  vt_addr = '0;
   logic [31:0] vt_wdata = '0;
   logic        frm_valid = 1'b0;
   logic        frm_ready;
   logic [15:0] frm_len = '0;
   logic [15:0] frm_type = '0;
   logic [11:0] frm_vid = '0;
   logic        desc_valid;
   logic [11:0] desc_idx;
   logic [16:0] desc_len;
   logic [7:0]  desc_status;
   logic [11:0] head, tail;
   logic        drop;
   logic [2:0]  cause;
   logic [15:0] miss_cnt;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int m_head = 0, m_tail = 0, m_miss = 0, m_size = 0;
   bit vt_m [4096];

   always #10 clk = ~clk;

   rxr_ring_acct dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_ctrl_i(cfg_ctrl), .cfg_ring_bytes_i(cfg_ring_bytes),
      .cfg_vlan_type_i(cfg_vlan_type), .cfg_small_thr_i(cfg_small_thr),
      .tail_we_i(tail_we), .tail_wdata_i(tail_wdata),
      .vt_we_i(vt_we), .vt_addr_i(vt_addr), .vt_wdata_i(vt_wdata),
      .frm_valid_i(frm_valid), .frm_ready_o(frm_ready), .frm_len_i(frm_len),
      .frm_type_i(frm_type), .frm_vid_i(frm_vid),
      .desc_valid_o(desc_valid), .desc_idx_o(desc_idx), .desc_len_o(desc_len),
      .desc_status_o(desc_status), .head_o(head), .tail_o(tail), .drop_o(drop),
      .cause_o(cause), .miss_cnt_o(miss_cnt)
   );

   task automatic chk(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [10:0] mk_ctrl(bit en, int lbk, bit lng, int sz, bit ext,
                                           bit vfe, int mts, bit strip);
      logic [10:0] c;
      c = '0;
      c[0] = en; c[2:1] = 2'(lbk); c[3] = lng; c[5:4] = 2'(sz); c[6] = ext;
      c[7] = vfe; c[9:8] = 2'(mts); c[10] = strip;
      return c;
   endfunction

   function automatic int f_buf(logic [10:0] c);
      if (!c[6]) begin
         case (c[5:4]) 2'd0: return 2048; 2'd1: return 1024; 2'd2: return 512; default: return 256; endcase
      end else begin
         case (c[5:4]) 2'd1: return 16384; 2'd2: return 8192; 2'd3: return 4096; default: return 256; endcase
      end
   endfunction

   function automatic int f_adj(logic [10:0] c, int len);
      int a;
      a = (len < 60) ? 60 : len;
      return c[10] ? a : a + 4;
   endfunction

   function automatic int f_free(int hd);
      if (m_size == 0) return 0;
      return (m_size + m_tail - hd) % m_size;
   endfunction

   task automatic set_cfg(logic [10:0] c, int size, int thr);
      @(negedge clk);
      cfg_ctrl = c; cfg_ring_bytes = 16'(size * 16); cfg_small_thr = 16'(thr);
      m_size = size;
   endtask

   task automatic set_tail(int t);
      @(negedge clk);
      tail_we = 1'b1; tail_wdata = 12'(t);
      @(negedge clk);
      tail_we = 1'b0;
      m_tail = t;
   endtask

   task automatic vt_write(int a, logic [31:0] d);
      @(negedge clk);
      vt_we = 1'b1; vt_addr = 7'(a); vt_wdata = d;
      @(negedge clk);
      vt_we = 1'b0;
      for (int b = 0; b < 32; b++) vt_m[a*32 + b] = d[b];
   endtask

   task automatic send(string tag, int len, logic [15:0] typ, int vid);
      logic [10:0] c;
      int bsz, adj, maxfr, resv, n, fr, lim;
      bit off, rej_room, rej_vlan;
      logic [2:0] exp_cause;
      c = cfg_ctrl;
      bsz = f_buf(c);
      adj = f_adj(c, len);
      maxfr = c[3] ? 16384 : 1522;
      resv = (maxfr + bsz - 1) / bsz;
      n = (adj + bsz - 1) / bsz;
      fr = f_free(m_head);
      off = !c[0] || (c[2:1] != 2'b00);
      rej_room = !off && (fr < resv);
      rej_vlan = !off && !rej_room && c[7] && (typ == cfg_vlan_type) && !vt_m[vid];
      @(negedge clk);
      frm_valid = 1'b1; frm_len = 16'(len); frm_type = typ; frm_vid = 12'(vid);
      @(negedge clk);
      frm_valid = 1'b0;
      if (off || rej_room || rej_vlan) begin
         if (rej_room) m_miss++;
         chk({tag, " drop pulse"}, drop, 1);
         chk({tag, " no desc on drop"}, desc_valid, 0);
         chk({tag, " no cause on drop"}, cause, 0);
         chk({tag, " head kept"}, head, m_head);
         chk({tag, " miss count"}, miss_cnt, m_miss);
      end else begin
         for (int i = 0; i < n; i++) begin
            chk({tag, " R4 desc valid"}, desc_valid, 1);
            chk({tag, " R10 ready low"}, frm_ready, 0);
            chk({tag, " R5 desc index"}, desc_idx, (m_head + i) % m_size);
            chk({tag, " R4 desc len"}, desc_len, (i == n - 1) ? (adj % bsz) : bsz);
            chk({tag, " R4 desc status"}, desc_status, (i == n - 1) ? 7 : 1);
            @(negedge clk);
         end
         m_head = (m_head + n) % m_size;
         exp_cause = 3'b001;
         if (adj <= int'(cfg_small_thr)) exp_cause[1] = 1'b1;
         lim = m_size >> (int'(c[9:8]) + 1);
         if (f_free(m_head) < lim) exp_cause[2] = 1'b1;
         chk({tag, " R7 R8 cause"}, cause, exp_cause);
         chk({tag, " R5 head"}, head, m_head);
         chk({tag, " R10 ready back"}, frm_ready, 1);
         chk({tag, " R2 no drop"}, drop, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int sz_list [8];
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset R5 head", head, 0);
      chk("reset R10 ready", frm_ready, 1);
      chk("reset R4 desc valid", desc_valid, 0);
      chk("reset R7 cause", cause, 0);
      chk("reset R2 miss", miss_cnt, 0);

      cfg_vlan_type = 16'h8100;
      set_cfg(mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0), 16, 64);
      set_tail(15);
      send("R3 R7 short frame small", 10, 16'h0800, 0);
      send("R7 not small", 100, 16'h0800, 0);
      set_cfg(mk_ctrl(1, 0, 0, 3, 0, 0, 0, 0), 16, 0);
      set_tail((m_head + 15) % 16);
      send("R4 four descs 256", 1000, 16'h0800, 0);
      set_tail((m_head + 15) % 16);
      send("R4 exact multiple last len 0", 508, 16'h0800, 0);
      set_cfg(mk_ctrl(1, 0, 0, 3, 0, 0, 0, 1), 16, 0);
      set_tail((m_head + 15) % 16);
      send("R3 strip", 508, 16'h0800, 0);

      for (int s = 0; s < 8; s++) begin
         set_cfg(mk_ctrl(1, 0, s >= 4, s % 4, s >= 4, 0, 0, 0), 16, 0);
         set_tail((m_head + 15) % 16);
         send("R1 R5 size sweep", 1500, 16'h0800, 0);
      end
      set_cfg(mk_ctrl(1, 0, 1, 1, 1, 0, 0, 0), 16, 0);
      set_tail((m_head + 15) % 16);
      send("R1 long 16384 buffer", 16000, 16'h0800, 0);

      set_cfg(mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0), 16, 0);
      set_tail(m_head);
      send("R2 empty ring drop", 64, 16'h0800, 0);
      set_cfg(mk_ctrl(1, 0, 0, 3, 0, 0, 0, 0), 16, 0);
      set_tail((m_head + 5) % 16);
      send("R2 free 5 below reserve 6", 64, 16'h0800, 0);
      set_tail((m_head + 6) % 16);
      send("R2 R8 free 6 equals reserve", 64, 16'h0800, 0);

      set_cfg(mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0), 16, 0);
      set_tail((m_head + 6) % 16);
      send("R8 low at half", 64, 16'h0800, 0);
      set_cfg(mk_ctrl(1, 0, 0, 0, 0, 0, 3, 0), 16, 0);
      set_tail((m_head + 6) % 16);
      send("R8 not low at sixteenth", 64, 16'h0800, 0);

      vt_write(0, 32'h0000_0020);
      vt_write(127, 32'h8000_0000);
      set_cfg(mk_ctrl(1, 0, 0, 0, 0, 1, 0, 0), 16, 0);
      set_tail((m_head + 15) % 16);
      send("R6 known tag 5", 64, 16'h8100, 5);
      send("R6 unknown tag 6 drop", 64, 16'h8100, 6);
      send("R6 other ethertype passes", 64, 16'h0800, 6);
      send("R6 top tag 4095", 64, 16'h8100, 4095);

      set_cfg(mk_ctrl(0, 0, 0, 0, 0, 0, 0, 0), 16, 0);
      send("R9 disabled drop", 64, 16'h0800, 0);
      set_cfg(mk_ctrl(1, 2, 0, 0, 0, 0, 0, 0), 16, 0);
      send("R9 loopback drop", 64, 16'h0800, 0);

      set_cfg(mk_ctrl(1, 0, 0, 3, 0, 0, 0, 0), 16, 0);
      set_tail((m_head + 15) % 16);
      @(negedge clk);
      frm_valid = 1'b1; frm_len = 16'd1000; frm_type = 16'h0800;
      @(negedge clk);
      @(negedge clk);
      frm_valid = 1'b0;
      for (int i = 0; i < 3; i++) @(negedge clk);
      m_head = (m_head + 4) % 16;
      chk("R10 frame while busy ignored head", head, m_head);
      chk("R10 frame while busy ignored desc", desc_valid, 0);
      @(negedge clk);

      for (int t = 0; t < 32; t++) vt_write(t * 4, $urandom);
      for (int k = 0; k < 400; k++) begin
         int sz, ext, lng, strip, lim, len, size;
         sz = $urandom % 4; ext = $urandom % 2; lng = $urandom % 2; strip = $urandom % 2;
         size = m_head + 1 + ($urandom % 120);
         set_cfg(mk_ctrl(($urandom % 10) != 0, (($urandom % 12) == 0) ? 1 : 0, lng[0], sz,
                         ext[0], $urandom % 2, $urandom % 4, strip[0]), size, $urandom % 400);
         set_tail($urandom % size);
         lim = (lng ? 16384 : 1522) - (strip ? 0 : 4);
         len = (($urandom % 3) == 0) ? ($urandom % 80) : ($urandom % (lim + 1));
         send("random R1 R2 R3 R4 R6 R7 R8", len, (($urandom % 2) == 0) ? 16'h8100 : 16'h86dd,
              $urandom % 4096);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule